// File: doc/BRIEF.md
# Stepped Transmit Level Controller

This block is the digital half of a transmit level-control loop. An external peak-sensing front end supplies two comparator levels. One says the feedback amplitude is above a lower bound. The other says it is above an upper bound. The block returns a 5-bit attenuation index that drives a 32-step variable-gain stage. Index 0 is full gain (0 dB). Each higher index adds about 0.84 dB of attenuation, down to roughly −26 dB at index 31.

A free-running timer divides time into control periods. At 11.0592 MHz a period is 1536 clocks, which gives a 7200 Hz rate. The first part of each period is blanking, during which the analog stage settles after a gain change and the comparators are ignored. The rest of the period is the detection window, during which each comparator is tracked by a sticky flag. On the last clock of the period the flags select the step. An upper crossing adds one step of attenuation. No lower crossing at all removes one step. Anything else holds the index. The new index appears together with a one-clock update pulse on the first clock of the next period, and the flags start clear again.

Top module: `alc_stepper`

## Requirements
- R1: While reset is high, the index output is 0 and the update pulse is low; after release the index stays 0 until the first update.
- R2: The update pulse is high for exactly one clock every CLK_PER_PERIOD clocks. It is first high in the cycle after the CLK_PER_PERIOD-th rising edge with reset low. The index output changes in that cycle and at no other time.
- R3: Each comparator input passes through two flip-flops before use. A level counts for a period only if that second flop shows it while the period counter (0 at period start) is between BLANK_CLKS and CLK_PER_PERIOD−1 inclusive; both end counts are part of the window.
- R4: If the upper-bound input was seen high at any counted clock of a period, the index increases by one (one step more attenuation).
- R5: If neither input was seen high at any counted clock of a period, the index decreases by one (one step more gain).
- R6: If the lower-bound input was seen high and the upper-bound input was not, the index is unchanged.
- R7: The index saturates: an increase at 31 leaves 31 and a decrease at 0 leaves 0, with no wrap.
- R8: The index never changes by more than one step per update.
- R9: The detection flags start every period clear: crossings in one period have no effect on the decision of the next.
- R10: Comparator levels seen by the second flop during the blanking counts (0 to BLANK_CLKS−1) have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| above_low_i | input | 1 | Asynchronous comparator: feedback peak above the lower bound |
| above_high_i | input | 1 | Asynchronous comparator: feedback peak above the upper bound |
| gain_idx_o | output | 5 | Attenuation index, 0 = 0 dB, +~0.84 dB per step |
| gain_upd_o | output | 1 | One-clock pulse in the cycle a new index takes effect |

## Verification
Two situations are hard to reach from the ports. The first is a single-clock comparator pulse that lands, after the two synchronizer flops, exactly on the first or the last count of the detection window, or on the last blanking count. The bench reaches it by sweeping a one-clock pulse across every position of a shortened period, with each input swept separately. The second is saturation at index 31, which needs over thirty consecutive periods with upper crossings, and release from there. Long runs of constant stimulus at both extremes reach it, followed by a pseudo-random per-clock pattern.

// File: rtl/alc_pkg.sv
package alc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_BOOST = 2'd1,  // one step more gain (index down)
    STEP_ATTN  = 2'd2   // one step more attenuation (index up)
  } step_e;

  function automatic step_e pick_step(input logic lo_seen, input logic hi_seen);
    if (hi_seen)      return STEP_ATTN;
    else if (!lo_seen) return STEP_BOOST;
    else              return STEP_HOLD;
  endfunction

endpackage

// File: rtl/alc_sync.sv
module alc_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/alc_period_timer.sv
module alc_period_timer #(
  parameter int CLK_PER_PERIOD = 1536,
  parameter int BLANK_CLKS     = 384
) (
  input  logic clk,
  input  logic rst,
  output logic detect_o,
  output logic period_end_o
);

  localparam int CNT_W = (CLK_PER_PERIOD > 1) ? $clog2(CLK_PER_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(CLK_PER_PERIOD - 1);
  localparam logic [CNT_W-1:0] OPEN_CNT  = CNT_W'(BLANK_CLKS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                   cnt_q <= '0;
    else if (cnt_q == LAST_CNT) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign detect_o     = (cnt_q >= OPEN_CNT);
  assign period_end_o = (cnt_q == LAST_CNT);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_CNT);  // R2

  AST_WRAP_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    period_end_o |=> (cnt_q == '0));  // R2

endmodule

// File: rtl/alc_peak_tracker.sv
module alc_peak_tracker (
  input  logic clk,
  input  logic rst,
  input  logic detect_i,
  input  logic period_end_i,
  input  logic lo_sync_i,
  input  logic hi_sync_i,
  output logic lo_any_o,
  output logic hi_any_o
);

  logic lo_seen_q, hi_seen_q;

  always_ff @(posedge clk) begin
    if (rst || period_end_i) begin
      lo_seen_q <= 1'b0;
      hi_seen_q <= 1'b0;
    end else if (detect_i) begin
      lo_seen_q <= lo_seen_q | lo_sync_i;
      hi_seen_q <= hi_seen_q | hi_sync_i;
    end
  end

  // Include the level present on the final counted clock.
  assign lo_any_o = lo_seen_q | (detect_i & lo_sync_i);
  assign hi_any_o = hi_seen_q | (detect_i & hi_sync_i);

  AST_BLANK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !detect_i |-> (!lo_seen_q && !hi_seen_q));  // R10

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hi_seen_q && !period_end_i) |=> hi_seen_q);  // R4

  AST_CLEAR_AT_END: assert property (@(posedge clk) disable iff (rst)
    period_end_i |=> (!lo_seen_q && !hi_seen_q));  // R9

endmodule

// File: rtl/alc_step_reg.sv
module alc_step_reg
  import alc_pkg::*;
#(
  parameter int GAIN_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              period_end_i,
  input  logic              lo_any_i,
  input  logic              hi_any_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              upd_o
);

  localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};

  step_e             step;
  logic [GAIN_W-1:0] gain_q, gain_nxt;
  logic              upd_q;

  always_comb begin
    step = pick_step(lo_any_i, hi_any_i);
    unique case (step)
      STEP_ATTN:  gain_nxt = (gain_q == GAIN_MAX) ? gain_q : gain_q + 1'b1;
      STEP_BOOST: gain_nxt = (gain_q == '0)       ? gain_q : gain_q - 1'b1;
      default:    gain_nxt = gain_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= period_end_i;
      if (period_end_i) gain_q <= gain_nxt;
    end
  end

  assign gain_o = gain_q;
  assign upd_o  = upd_q;

  AST_CHANGE_ON_UPD: assert property (@(posedge clk) disable iff (rst)
    !upd_q |-> (gain_q == $past(gain_q)));  // R2

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> ((gain_q == $past(gain_q)) ||
               (gain_q == $past(gain_q) + 1'b1) ||
               (gain_q == $past(gain_q) - 1'b1)));  // R8

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
    (gain_q == GAIN_MAX) |=> (gain_q != '0));  // R7

  AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (rst)
    (gain_q == '0) |=> (gain_q != GAIN_MAX));  // R7

  AST_HI_ATTN: assert property (@(posedge clk) disable iff (rst)
    (period_end_i && hi_any_i && gain_q != GAIN_MAX) |=> (gain_q == $past(gain_q) + 1'b1));  // R4

endmodule

// File: rtl/alc_stepper.sv
module alc_stepper #(
  parameter int CLK_PER_PERIOD = 1536,
  parameter int BLANK_CLKS     = 384,
  parameter int GAIN_W         = 5,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              above_low_i,
  input  logic              above_high_i,
  output logic [GAIN_W-1:0] gain_idx_o,
  output logic              gain_upd_o
);

  logic [1:0] cmp_sync;
  logic       detect, period_end;
  logic       lo_any, hi_any;

  alc_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({above_high_i, above_low_i}),
    .q_o (cmp_sync)
  );

  alc_period_timer #(.CLK_PER_PERIOD(CLK_PER_PERIOD), .BLANK_CLKS(BLANK_CLKS)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .detect_o     (detect),
    .period_end_o (period_end)
  );

  alc_peak_tracker u_track (
    .clk          (clk),
    .rst          (rst),
    .detect_i     (detect),
    .period_end_i (period_end),
    .lo_sync_i    (cmp_sync[0]),
    .hi_sync_i    (cmp_sync[1]),
    .lo_any_o     (lo_any),
    .hi_any_o     (hi_any)
  );

  alc_step_reg #(.GAIN_W(GAIN_W)) u_step (
    .clk          (clk),
    .rst          (rst),
    .period_end_i (period_end),
    .lo_any_i     (lo_any),
    .hi_any_i     (hi_any),
    .gain_o       (gain_idx_o),
    .upd_o        (gain_upd_o)
  );

  AST_UPD_AT_START: assert property (@(posedge clk) disable iff (rst)
    gain_upd_o |-> !detect);  // R2

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    gain_upd_o |=> !gain_upd_o);  // R2

endmodule

// File: tb/alc_stepper_tb.sv
module alc_stepper_tb;

  localparam int P  = 16;
  localparam int B  = 4;
  localparam int GW = 5;
  localparam int GMAX = 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lo_in = 1'b0, hi_in = 1'b0;
  logic [GW-1:0] gain;
  logic upd;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  alc_stepper #(.CLK_PER_PERIOD(P), .BLANK_CLKS(B), .GAIN_W(GW), .SYNC_STAGES(2)) u_dut (
    .clk (clk), .rst (rst),
    .above_low_i (lo_in), .above_high_i (hi_in),
    .gain_idx_o (gain), .gain_upd_o (upd)
  );

  // Behavioural expectation built from the requirements
  int    m_cnt, m_gain, m_prev_gain;
  logic  m_s1lo, m_s1hi, m_s2lo, m_s2hi;
  logic  m_lo, m_hi, m_blank_ev, m_edge_ev, m_prev_hi, m_upd;
  string m_tag;

  always @(posedge clk) begin
    logic lo_f, hi_f;
    if (rst) begin
      m_cnt = 0; m_gain = 0; m_s1lo = 0; m_s1hi = 0; m_s2lo = 0; m_s2hi = 0;
      m_lo = 0; m_hi = 0; m_blank_ev = 0; m_edge_ev = 0; m_prev_hi = 0; m_upd = 0;
      m_tag = "R1";
    end else begin
      m_upd = 0;
      if (m_cnt < B) begin
        if (m_s2lo || m_s2hi) m_blank_ev = 1;  // R10
      end else begin
        if ((m_cnt == B || m_cnt == P-1) && (m_s2lo || m_s2hi)) m_edge_ev = 1;  // R3
        m_lo = m_lo | m_s2lo;
        m_hi = m_hi | m_s2hi;
      end
      if (m_cnt == P-1) begin
        lo_f = m_lo; hi_f = m_hi;
        if (hi_f)       begin m_gain = (m_gain == GMAX) ? GMAX : m_gain + 1; m_tag = "R4"; end
        else if (!lo_f) begin m_gain = (m_gain == 0) ? 0 : m_gain - 1;       m_tag = "R5"; end
        else                                                               m_tag = "R6";
        if (m_prev_hi && !hi_f) m_tag = "R9";
        if (m_blank_ev)         m_tag = "R10";
        if (m_edge_ev)          m_tag = "R3";
        if ((hi_f && m_gain == GMAX) || (!hi_f && !lo_f && m_gain == 0)) m_tag = "R7";
        m_prev_hi = hi_f;
        m_lo = 0; m_hi = 0; m_blank_ev = 0; m_edge_ev = 0;
        m_upd = 1;
        m_cnt = 0;
      end else begin
        m_cnt = m_cnt + 1;
      end
      m_s2lo = m_s1lo; m_s2hi = m_s1hi;
      m_s1lo = lo_in;  m_s1hi = hi_in;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(upd == m_upd, "R2", int'(upd), int'(m_upd));
      check(int'(gain) == m_gain, m_upd ? m_tag : "R8", int'(gain), m_gain);
      if (!m_upd) check(int'(gain) == m_prev_gain, "R8", int'(gain), m_prev_gain);
      m_prev_gain = int'(gain);
    end
  end

  logic [15:0] lfsr = 16'hACE1;

  // mode: 0 quiet, 1 both high, 2 low held + one-clock high pulse, 3 one-clock low pulse, 4 random
  task automatic run_period(input int mode, input int pos);
    for (int c = 0; c < P; c++) begin
      @(negedge clk);
      case (mode)
        0: begin lo_in = 0; hi_in = 0; end
        1: begin lo_in = 1; hi_in = 1; end
        2: begin lo_in = 1; hi_in = (c == pos); end
        3: begin lo_in = (c == pos); hi_in = 0; end
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          lo_in = lfsr[0] | lfsr[3];
          hi_in = lfsr[1] & lfsr[5] & lfsr[7];
        end
      endcase
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(gain == '0, "R1", int'(gain), 0);
    check(upd == 1'b0, "R1", int'(upd), 0);
    rst = 1'b0;
    m_prev_gain = 0;
    // R4: climb well away from both limits
    repeat (10) run_period(1, 0);
    // R3 R10: single upper pulse swept over every position
    for (int p = 0; p < P; p++) run_period(2, p);
    // R3 R5 R6: single lower pulse swept over every position
    for (int p = 0; p < P; p++) run_period(3, p);
    // R7: drive index to the lower limit
    repeat (35) run_period(0, 0);
    @(negedge clk);
    check(gain == '0, "R7", int'(gain), 0);
    // R7: drive index to the upper limit
    repeat (40) run_period(1, 0);
    @(negedge clk);
    check(int'(gain) == GMAX, "R7", int'(gain), GMAX);
    // R9: one quiet period right after saturation
    run_period(0, 0);
    // mixed traffic
    repeat (60) run_period(4, 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule